// File: doc/BRIEF.md
# Relocatable Protected Data SRAM Banks

This block places four independent 1 KB data SRAM banks on the processor's data path. Software gives each bank its own 1 KB-aligned base address, an enable bit and two protection attributes: supervisor-only and read-only. Every memory request is decoded against all enabled banks. The bank with the lowest index among those that match serves the request, and its protection is checked before any storage is touched. The banks are plain addressable storage. They never hold copies of external memory.

A request enters on a valid/ready channel. Its outcome leaves on a second valid/ready channel one cycle after the request is accepted. The outcome is one of three kinds: served (with read data for reads), refused by protection (fault), or claimed by no bank (unclaimed, so an external bus can take it). Back-pressure works like this: a response stays on the outputs, unchanged, until `rsp_ready` is high. While a response waits, `req_ready` is low. This makes the block a single-entry pipeline that never drops or reorders a result. The configuration port is a plain write strobe. A configuration written in a cycle applies to requests accepted in later cycles.

Top module: `reloc_dsram`

## Requirements
- R1: There are four banks of 1 KB each. Inside a bank, request address bits [9:2] select one of 256 32-bit words, and address bits [1:0] are ignored.
- R2: A configuration write with `cfg_we` high sets base, enable, supervisor-only and read-only for the bank named by `cfg_sel`. Requests accepted in the same cycle still see the previous settings.
- R3: A bank matches when its enable bit is 1 and request address bits [31:10] equal its base. When several banks match, the lowest index serves the access.
- R4: If the serving bank is supervisor-only and `req_sup` is 0, the access is refused. The response then has `rsp_fault`=1 and `rsp_hit`=1, and a write leaves storage unchanged.
- R5: If the serving bank is read-only, a write is refused with `rsp_fault`=1 and storage is unchanged. Reads of that bank are served.
- R6: On a served write, byte lane i (`req_be[i]`=1) stores `req_wdata[8i+7:8i]`. Lanes whose enable is 0 keep their previous value.
- R7: The response of an accepted request is valid on the first clock edge after acceptance. `rsp_rdata` carries the word for a served read and is 0 for writes, faults and unclaimed accesses.
- R8: An address that no enabled bank matches gives `rsp_unclaimed`=1 and `rsp_hit`=0. It changes no bank.
- R9: `req_ready` equals NOT `rsp_valid` OR `rsp_ready`. While `rsp_valid`=1 and `rsp_ready`=0, every response output holds its value.
- R10: After reset all banks are disabled, `rsp_valid` is 0 and `req_ready` is 1.
- R11: A valid response has exactly one of `rsp_hit` and `rsp_unclaimed` set, and `rsp_fault` is set only together with `rsp_hit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Bank being configured |
| cfg_base | input | 22 | New base, address bits [31:10] |
| cfg_en | input | 1 | New enable bit |
| cfg_sup_only | input | 1 | New supervisor-only attribute |
| cfg_rd_only | input | 1 | New read-only attribute |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_addr | input | 32 | Byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_be | input | 4 | Byte-lane enables for writes |
| req_wdata | input | 32 | Write data |
| req_sup | input | 1 | 1 = supervisor mode, 0 = user mode |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response consumer can take it |
| rsp_rdata | output | 32 | Read data of a served read, else 0 |
| rsp_hit | output | 1 | An enabled bank matched the address |
| rsp_fault | output | 1 | Access refused by protection |
| rsp_unclaimed | output | 1 | No enabled bank matched |

## Verification
A configuration write and a memory request can land on the same clock edge. The request must then be judged against the old settings, and the new settings apply from the next request onward. The bench provokes this with directed cases. In one, a bank is disabled, and in another it is made supervisor-only, in the very cycle that an access to it is accepted; a follow-up access then shows the new setting. The random phase also mixes configuration writes into the request stream. A bench reference model is always updated only after the expected result of the same-cycle request has been computed.

// File: rtl/rpd_pkg.sv
package rpd_pkg;
  localparam int DEF_BANKS      = 4;
  localparam int DEF_ADDR_W     = 32;
  localparam int DEF_DATA_W     = 32;
  localparam int DEF_BANK_BYTES = 1024;

  typedef enum logic [1:0] {
    KIND_DONE  = 2'd0,
    KIND_FAULT = 2'd1,
    KIND_MISS  = 2'd2
  } rsp_kind_e;
endpackage

// File: rtl/rpd_cfg_regs.sv
module rpd_cfg_regs #(
  parameter int NUM_BANKS = 4,
  parameter int BASE_W    = 22,
  parameter int SEL_W     = 2
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               wr,
  input  logic [SEL_W-1:0]                   sel,
  input  logic [BASE_W-1:0]                  base_in,
  input  logic                               en_in,
  input  logic                               sup_in,
  input  logic                               ro_in,
  output logic [NUM_BANKS-1:0][BASE_W-1:0]   base_q,
  output logic [NUM_BANKS-1:0]               en_q,
  output logic [NUM_BANKS-1:0]               sup_q,
  output logic [NUM_BANKS-1:0]               ro_q
);
  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q[g] <= '0;
        en_q[g]   <= 1'b0;
        sup_q[g]  <= 1'b0;
        ro_q[g]   <= 1'b0;
      end else if (wr && (sel == SEL_W'(g))) begin
        base_q[g] <= base_in;
        en_q[g]   <= en_in;
        sup_q[g]  <= sup_in;
        ro_q[g]   <= ro_in;
      end
    end
  end

  AST_CFG_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (en_q[$past(sel)] == $past(en_in)) && (base_q[$past(sel)] == $past(base_in))); // R2
endmodule

// File: rtl/rpd_decode.sv
module rpd_decode #(
  parameter int NUM_BANKS = 4,
  parameter int BASE_W    = 22,
  parameter int IDX_W     = 2
) (
  input  logic [BASE_W-1:0]                 addr_hi,
  input  logic                              is_write,
  input  logic                              is_sup,
  input  logic [NUM_BANKS-1:0][BASE_W-1:0]  base,
  input  logic [NUM_BANKS-1:0]              en,
  input  logic [NUM_BANKS-1:0]              sup_only,
  input  logic [NUM_BANKS-1:0]              rd_only,
  output logic                              hit,
  output logic [IDX_W-1:0]                  idx,
  output logic [NUM_BANKS-1:0]              sel,
  output logic                              deny
);
  logic [NUM_BANKS-1:0] match;

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_cmp
    assign match[g] = en[g] && (base[g] == addr_hi);
  end

  // lowest index wins: scan downward so the last assignment is the lowest
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = NUM_BANKS - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit = 1'b1;
        idx = IDX_W'(i);
      end
    end
    sel = hit ? (NUM_BANKS'(1) << idx) : '0;
  end

  assign deny = hit && ((sup_only[idx] && !is_sup) || (rd_only[idx] && is_write));
endmodule

// File: rtl/rpd_bank.sv
module rpd_bank #(
  parameter int DATA_W = 32,
  parameter int WORDS  = 256,
  parameter int WORD_W = 8,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              we,
  input  logic [WORD_W-1:0] word,
  input  logic [LANES-1:0]  be,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) begin
        for (int b = 0; b < LANES; b++) begin
          if (be[b]) mem[word][8*b +: 8] <= wdata[8*b +: 8];
        end
      end else begin
        rdata <= mem[word];
      end
    end
  end

  AST_BANK_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(rdata)); // R9
endmodule

// File: rtl/reloc_dsram.sv
module reloc_dsram
  import rpd_pkg::*;
#(
  parameter int NUM_BANKS  = DEF_BANKS,
  parameter int ADDR_W     = DEF_ADDR_W,
  parameter int DATA_W     = DEF_DATA_W,
  parameter int BANK_BYTES = DEF_BANK_BYTES,
  localparam int LANES   = DATA_W / 8,
  localparam int LANE_W  = $clog2(LANES),
  localparam int OFS_W   = $clog2(BANK_BYTES),
  localparam int BASE_W  = ADDR_W - OFS_W,
  localparam int WORDS   = BANK_BYTES / LANES,
  localparam int WORD_W  = $clog2(WORDS),
  localparam int IDX_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_sel,
  input  logic [BASE_W-1:0] cfg_base,
  input  logic              cfg_en,
  input  logic              cfg_sup_only,
  input  logic              cfg_rd_only,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [LANES-1:0]  req_be,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_sup,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_hit,
  output logic              rsp_fault,
  output logic              rsp_unclaimed
);
  logic [NUM_BANKS-1:0][BASE_W-1:0] c_base;
  logic [NUM_BANKS-1:0]             c_en, c_sup, c_ro;
  logic                             d_hit, d_deny;
  logic [IDX_W-1:0]                 d_idx;
  logic [NUM_BANKS-1:0]             d_sel;
  logic [NUM_BANKS-1:0]             bank_en;
  logic [NUM_BANKS-1:0][DATA_W-1:0] bank_rdata;
  logic                             accept;
  logic [WORD_W-1:0]                word;
  logic [LANE_W-1:0]                unused_lsb;

  rsp_kind_e        kind_q;
  logic             rd_q;
  logic [IDX_W-1:0] idx_q;

  assign unused_lsb = req_addr[LANE_W-1:0];
  assign word       = req_addr[OFS_W-1:LANE_W];
  assign req_ready  = !rsp_valid || rsp_ready;
  assign accept     = req_valid && req_ready;

  rpd_cfg_regs #(.NUM_BANKS(NUM_BANKS), .BASE_W(BASE_W), .SEL_W(IDX_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(cfg_we), .sel(cfg_sel), .base_in(cfg_base),
    .en_in(cfg_en), .sup_in(cfg_sup_only), .ro_in(cfg_rd_only),
    .base_q(c_base), .en_q(c_en), .sup_q(c_sup), .ro_q(c_ro)
  );

  rpd_decode #(.NUM_BANKS(NUM_BANKS), .BASE_W(BASE_W), .IDX_W(IDX_W)) u_dec (
    .addr_hi(req_addr[ADDR_W-1:OFS_W]), .is_write(req_write), .is_sup(req_sup),
    .base(c_base), .en(c_en), .sup_only(c_sup), .rd_only(c_ro),
    .hit(d_hit), .idx(d_idx), .sel(d_sel), .deny(d_deny)
  );

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    assign bank_en[g] = accept && d_sel[g] && !d_deny;
    rpd_bank #(.DATA_W(DATA_W), .WORDS(WORDS), .WORD_W(WORD_W), .LANES(LANES)) u_bank (
      .clk(clk), .rst_n(rst_n), .en(bank_en[g]), .we(req_write), .word(word),
      .be(req_be), .wdata(req_wdata), .rdata(bank_rdata[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      kind_q    <= KIND_MISS;
      rd_q      <= 1'b0;
      idx_q     <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      idx_q     <= d_idx;
      rd_q      <= d_hit && !d_deny && !req_write;
      if (!d_hit)      kind_q <= KIND_MISS;
      else if (d_deny) kind_q <= KIND_FAULT;
      else             kind_q <= KIND_DONE;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  assign rsp_rdata     = (rsp_valid && rd_q) ? bank_rdata[idx_q] : '0;
  assign rsp_hit       = rsp_valid && (kind_q != KIND_MISS);
  assign rsp_fault     = rsp_valid && (kind_q == KIND_FAULT);
  assign rsp_unclaimed = rsp_valid && (kind_q == KIND_MISS);

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_hit != rsp_unclaimed)); // R11
  AST_FAULT_HAS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> rsp_hit); // R11
  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_rdata) && $stable(rsp_fault)
      && $stable(rsp_unclaimed)); // R9
  AST_FAULT_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_fault || rsp_unclaimed) |-> (rsp_rdata == '0)); // R7
  AST_MISS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !d_hit) |-> (bank_en == '0)); // R8
  AST_ONE_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_en)); // R3
endmodule

// File: tb/reloc_dsram_bench.sv
module reloc_dsram_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [21:0] cfg_base = '0;
  logic        cfg_en = 1'b0, cfg_sup_only = 1'b0, cfg_rd_only = 1'b0;
  logic        req_valid = 1'b0, req_ready;
  logic [31:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic [3:0]  req_be = '0;
  logic [31:0] req_wdata = '0;
  logic        req_sup = 1'b0;
  logic        rsp_valid, rsp_ready = 1'b1;
  logic [31:0] rsp_rdata;
  logic        rsp_hit, rsp_fault, rsp_unclaimed;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [21:0] m_base [4];
  logic        m_en [4], m_sup [4], m_ro [4];
  logic [31:0] m_mem [4][256];

  always #5 clk = ~clk;

  reloc_dsram u_reloc_dsram (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_base(cfg_base),
    .cfg_en(cfg_en), .cfg_sup_only(cfg_sup_only), .cfg_rd_only(cfg_rd_only),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_write(req_write), .req_be(req_be), .req_wdata(req_wdata), .req_sup(req_sup),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .rsp_hit(rsp_hit), .rsp_fault(rsp_fault), .rsp_unclaimed(rsp_unclaimed)
  );

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // packed response {valid, hit, fault, unclaimed, rdata}
  function automatic logic [35:0] observed();
    return {rsp_valid, rsp_hit, rsp_fault, rsp_unclaimed, rsp_rdata};
  endfunction

  task automatic model_cfg(input int b, input logic [21:0] base, input bit en, input bit sup, input bit ro);
    m_base[b] = base; m_en[b] = en; m_sup[b] = sup; m_ro[b] = ro;
  endtask

  // reference outcome of one access; updates model storage
  task automatic model_access(input logic [31:0] a, input bit we, input logic [3:0] be,
                              input logic [31:0] wd, input bit sup, output logic [35:0] e);
    int w = -1;
    for (int i = 3; i >= 0; i--) if (m_en[i] && m_base[i] == a[31:10]) w = i;
    if (w < 0) e = {4'b1001, 32'h0};
    else if ((m_sup[w] && !sup) || (m_ro[w] && we)) e = {4'b1110, 32'h0};
    else if (we) begin
      for (int b = 0; b < 4; b++) if (be[b]) m_mem[w][a[9:2]][8*b +: 8] = wd[8*b +: 8];
      e = {4'b1100, 32'h0};
    end else e = {4'b1100, m_mem[w][a[9:2]]};
  endtask

  task automatic drive_cfg(input int b, input logic [21:0] base, input bit en, input bit sup, input bit ro);
    @(negedge clk);
    cfg_we = 1; cfg_sel = 2'(b); cfg_base = base; cfg_en = en; cfg_sup_only = sup; cfg_rd_only = ro;
    @(posedge clk); #1 cfg_we = 0;
    model_cfg(b, base, en, sup, ro);
  endtask

  task automatic access(input logic [31:0] a, input bit we, input logic [3:0] be,
                        input logic [31:0] wd, input bit sup, input string tag);
    logic [35:0] e;
    model_access(a, we, be, wd, sup, e);
    @(negedge clk);
    req_valid = 1; req_addr = a; req_write = we; req_be = be; req_wdata = wd; req_sup = sup;
    @(posedge clk); #1 req_valid = 0;
    @(negedge clk);
    chk(observed() === e, tag, 64'(observed()), 64'(e));
  endtask

  task automatic read_expect(input logic [31:0] a, input bit sup, input logic [35:0] e, input string tag);
    logic [35:0] m;
    model_access(a, 0, 4'h0, 32'h0, sup, m);
    @(negedge clk);
    req_valid = 1; req_addr = a; req_write = 0; req_be = 0; req_sup = sup;
    @(posedge clk); #1 req_valid = 0;
    @(negedge clk);
    chk(observed() === e && m === e, tag, 64'(observed()), 64'(e));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_up();
  end

  initial begin
    logic [35:0] e;
    logic [31:0] a;
    for (int b = 0; b < 4; b++) model_cfg(b, '0, 0, 0, 0);
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(rsp_valid === 0 && req_ready === 1, "R10 reset", {rsp_valid, req_ready}, 2'b01);
    rst_n = 1;
    // R10/R8: nothing enabled after reset
    access(32'h0000_0000, 0, 4'h0, 0, 1, "R10 R8 disabled after reset");

    // preload: banks at bases 1..4, fully writable
    for (int b = 0; b < 4; b++) drive_cfg(b, 22'(b + 1), 1, 0, 0);
    for (int b = 0; b < 4; b++)
      for (int w = 0; w < 256; w++) begin
        model_access({22'(b + 1), 8'(w), 2'b00}, 1, 4'hF, {8'(b), 8'(w), 16'hA5C3}, 1, e);
        @(negedge clk);
        req_valid = 1; req_addr = {22'(b + 1), 8'(w), 2'b00}; req_write = 1; req_be = 4'hF;
        req_wdata = {8'(b), 8'(w), 16'hA5C3}; req_sup = 1;
        @(posedge clk); #1 req_valid = 0;
      end

    // R1: word select by bits [9:2], low bits ignored
    read_expect({22'd3, 8'd77, 2'b11}, 0, {4'b1100, 8'd2, 8'd77, 16'hA5C3}, "R1 word select");
    // R8: unclaimed address
    access({22'd9, 10'h0}, 1, 4'hF, 32'hDEAD_BEEF, 1, "R8 unclaimed write");
    // R6: byte enables
    access({22'd1, 8'd5, 2'b00}, 1, 4'hF, 32'h1122_3344, 0, "R6 full write");
    access({22'd1, 8'd5, 2'b00}, 1, 4'b0101, 32'hAABB_CCDD, 0, "R6 partial write");
    read_expect({22'd1, 8'd5, 2'b00}, 0, {4'b1100, 32'h11BB_33DD}, "R6 merged lanes");
    // R3: overlap, bank 2 moved onto bank 1 window -> bank 1 serves
    drive_cfg(2, 22'd2, 1, 0, 0);
    read_expect({22'd2, 8'd9, 2'b00}, 0, {4'b1100, 8'd1, 8'd9, 16'hA5C3}, "R3 lowest index wins");
    drive_cfg(2, 22'd3, 1, 0, 0);
    // R4: supervisor-only bank
    drive_cfg(0, 22'd1, 1, 1, 0);
    access({22'd1, 8'd6, 2'b00}, 1, 4'hF, 32'h0BAD_0BAD, 0, "R4 user write refused");
    read_expect({22'd1, 8'd6, 2'b00}, 1, {4'b1100, 8'd0, 8'd6, 16'hA5C3}, "R4 storage unchanged");
    access({22'd1, 8'd6, 2'b00}, 0, 4'h0, 0, 0, "R4 user read refused");
    // R5: read-only bank
    drive_cfg(3, 22'd4, 1, 0, 1);
    access({22'd4, 8'd1, 2'b00}, 1, 4'hF, 32'h5555_5555, 1, "R5 write refused");
    read_expect({22'd4, 8'd1, 2'b00}, 0, {4'b1100, 8'd3, 8'd1, 16'hA5C3}, "R5 read served");

    // R2: config write and request in the same cycle (old settings apply)
    a = {22'd3, 8'd20, 2'b00};
    model_access(a, 0, 4'h0, 0, 0, e);
    @(negedge clk);
    cfg_we = 1; cfg_sel = 2'd2; cfg_base = 22'd3; cfg_en = 0; cfg_sup_only = 0; cfg_rd_only = 0;
    req_valid = 1; req_addr = a; req_write = 0; req_sup = 0;
    @(posedge clk); #1 cfg_we = 0; req_valid = 0;
    model_cfg(2, 22'd3, 0, 0, 0);
    @(negedge clk);
    chk(observed() === e, "R2 same-cycle disable uses old setting", 64'(observed()), 64'(e));
    access(a, 0, 4'h0, 0, 0, "R2 disable seen next request");
    a = {22'd2, 8'd30, 2'b00};
    model_access(a, 0, 4'h0, 0, 0, e);
    @(negedge clk);
    cfg_we = 1; cfg_sel = 2'd1; cfg_base = 22'd2; cfg_en = 1; cfg_sup_only = 1; cfg_rd_only = 0;
    req_valid = 1; req_addr = a; req_write = 0; req_sup = 0;
    @(posedge clk); #1 cfg_we = 0; req_valid = 0;
    model_cfg(1, 22'd2, 1, 1, 0);
    @(negedge clk);
    chk(observed() === e, "R2 same-cycle protect uses old setting", 64'(observed()), 64'(e));
    access(a, 0, 4'h0, 0, 0, "R2 protect seen next request");

    // R9: back-pressure
    model_access({22'd4, 8'd2, 2'b00}, 0, 4'h0, 0, 1, e);
    @(negedge clk);
    rsp_ready = 0;
    req_valid = 1; req_addr = {22'd4, 8'd2, 2'b00}; req_write = 0; req_sup = 1;
    @(posedge clk); #1 req_addr = {22'd4, 8'd3, 2'b00};
    @(negedge clk);
    chk(req_ready === 0 && observed() === e, "R9 stall holds response", {req_ready, observed()}, {1'b0, e});
    @(negedge clk);
    chk(req_ready === 0 && observed() === e, "R9 response stable", {req_ready, observed()}, {1'b0, e});
    model_access({22'd4, 8'd3, 2'b00}, 0, 4'h0, 0, 1, e);
    rsp_ready = 1;
    @(posedge clk); #1 req_valid = 0;
    @(negedge clk);
    chk(observed() === e, "R9 next request after release", 64'(observed()), 64'(e));

    // constrained random mix; R7 R11 on every response
    for (int n = 0; n < 1500; n++) begin
      int r = $urandom_range(0, 99);
      if (r < 8) begin
        drive_cfg($urandom_range(0, 3), 22'($urandom_range(1, 5)), $urandom_range(0, 9) != 0,
                  $urandom_range(0, 3) == 0, $urandom_range(0, 3) == 0);
      end else begin
        a = {22'($urandom_range(0, 6)), 8'($urandom_range(0, 255)), 2'($urandom_range(0, 3))};
        access(a, $urandom_range(0, 1), 4'($urandom_range(0, 15)), $urandom(), $urandom_range(0, 1),
               "R7 R11 random access");
      end
    end
    finish_up();
  end

  initial begin
    void'($urandom(32'd4242));
  end
endmodule